// File: doc/BRIEF.md
# Level/edge interrupt pending controller

This block gathers a parameterised set of shared peripheral interrupt lines for a single CPU. Every line keeps its own pending bit and active bit, and has its own trigger mode: level sensitive or edge triggered. From the pending, enabled and not-yet-active interrupts, the block always selects the most urgent one. When that interrupt's priority is more urgent than the current running priority, it raises one IRQ output.

Software works the block through four ports:
- an acknowledge read, which returns the selected interrupt ID and marks that interrupt active;
- an end-of-interrupt write, which retires an active interrupt;
- a clear-pending write;
- a write-only register port for the trigger, enable and priority fields.

The two trigger modes retire pending state in different ways. A level-sensitive interrupt follows its line. It survives acknowledge and clears only when the line falls. An edge-triggered interrupt latches a rising edge. It clears only on acknowledge or on a software clear.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A level-sensitive interrupt is pending in the cycle after any cycle where its line is high. It stops being pending in the cycle after its line is sampled low.
- R2: An edge-triggered interrupt becomes pending in the cycle after a rising edge of its line. It stays pending after the line falls, until it is acknowledged or cleared.
- R3: Write the trigger register (reg_sel=0) at word address n/16 to set the mode of interrupt n. Bit 2*(n mod 16)+1 of the written data selects the mode: 1 means edge, 0 means level. Reset leaves every interrupt level sensitive.
- R4: The selection is the pending, enabled, non-active interrupt with the numerically lowest priority. Ties go to the lowest ID. Priorities are written with reg_sel=2, address equal to the ID, and data[7:0]. Reset priority is 0.
- R5: run_prio is the lowest priority value among the active interrupts, or 0xFF when none is active. irq_out is high only when a selection exists and its priority is strictly lower than run_prio.
- R6: While irq_out is high, ack_id shows the selected ID. An acknowledge read marks that interrupt active and clears its pending bit only if it is edge triggered. A level interrupt stays pending.
- R7: While irq_out is low, ack_id is 1023, and an acknowledge read changes neither the active state nor run_prio.
- R8: An end-of-interrupt write clears the active bit of the interrupt whose ID it carries. An ID that is not active leaves the state unchanged.
- R9: A clear-pending write removes the pending state of an edge-triggered interrupt. It has no effect on a level-sensitive interrupt whose line is high.
- R10: An active interrupt is never selected, even while it is still pending.
- R11: An interrupt whose enable bit is 0 is never selected. Enables are written with reg_sel=1, where address w, bit j is interrupt 32w+j. Reset clears all enables.
- R12: With nothing selectable, irq_out is low and ack_id returns the spurious ID 1023. The spurious ID is never treated as level sensitive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_IRQ | Peripheral interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register bank: 0 trigger, 1 enable, 2 priority |
| reg_addr | input | ADDR_W | Word address or interrupt ID |
| reg_wdata | input | 32 | Register write data |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_id | output | 10 | Selected ID, or 1023 |
| eoi_we | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | ID being retired |
| clr_we | input | 1 | Clear-pending strobe |
| clr_id | input | 10 | ID whose pending state is cleared |
| irq_out | output | 1 | Interrupt request to the CPU |
| run_prio | output | PRIO_W | Current running priority |

## Verification
The assertions assume the following about software:
- an acknowledge read is issued only as a one-cycle strobe;
- end-of-interrupt and clear IDs are below 1024;
- the trigger mode of an interrupt changes only through the register port and never in the same cycle that the interrupt is acknowledged.

The stimulus writes the configuration one register per cycle. It then drives lines, acknowledges, end-of-interrupt writes and clears as single-cycle pulses, in directed sequences first and then from a seeded random stream. In the random stream, end-of-interrupt and clear IDs are drawn only from the implemented ID range.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
   localparam int ID_W = 10;
   localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
   localparam int TRIG_PER_WORD = 16;
   localparam int EN_PER_WORD   = 32;

   typedef enum logic [1:0] {
      BANK_TRIG   = 2'd0,
      BANK_ENABLE = 2'd1,
      BANK_PRIO   = 2'd2
   } reg_bank_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_pend_pkg::*;
#(
   parameter int NUM_IRQ = 32,
   parameter int PRIO_W  = 8,
   localparam int ADDR_W = $clog2(NUM_IRQ)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_we,
   input  logic [1:0]                reg_sel,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [31:0]               reg_wdata,
   output logic [NUM_IRQ-1:0]        edge_mode,
   output logic [NUM_IRQ-1:0]        enable,
   output logic [NUM_IRQ*PRIO_W-1:0] prio_flat
);
   reg_bank_e bank;
   assign bank = reg_bank_e'(reg_sel);

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cfg
      localparam int TRIG_WORD = i / TRIG_PER_WORD;
      localparam int TRIG_BIT  = 2 * (i % TRIG_PER_WORD) + 1;
      localparam int EN_WORD   = i / EN_PER_WORD;
      localparam int EN_BIT    = i % EN_PER_WORD;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            edge_mode[i]                 <= 1'b0;
            enable[i]                    <= 1'b0;
            prio_flat[i*PRIO_W +: PRIO_W] <= '0;
         end else if (reg_we) begin
            if (bank == BANK_TRIG && reg_addr == ADDR_W'(TRIG_WORD))
               edge_mode[i] <= reg_wdata[TRIG_BIT];
            if (bank == BANK_ENABLE && reg_addr == ADDR_W'(EN_WORD))
               enable[i] <= reg_wdata[EN_BIT];
            if (bank == BANK_PRIO && reg_addr == ADDR_W'(i))
               prio_flat[i*PRIO_W +: PRIO_W] <= reg_wdata[PRIO_W-1:0];
         end
      end
   end
endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic edge_mode,
   input  logic ack_hit,
   input  logic clr_hit,
   input  logic eoi_hit,
   output logic pend,
   output logic act
);
   logic line_q;
   logic rise;

   assign rise = line & ~line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         pend   <= 1'b0;
         act    <= 1'b0;
      end else begin
         line_q <= line;
         if (edge_mode)
            pend <= rise | (pend & ~ack_hit & ~clr_hit);
         else
            pend <= line;
         act <= ack_hit | (act & ~eoi_hit);
      end
   end

   assert_level_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode && !line) |=> !pend);

   assert_edge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && pend && !ack_hit && !clr_hit) |=> pend);

   assert_level_ack_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !edge_mode && line) |=> pend);

   assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !eoi_hit) |=> act);
endmodule

// File: rtl/irq_select.sv
module irq_select
   import irq_pend_pkg::*;
#(
   parameter int NUM_IRQ = 32,
   parameter int PRIO_W  = 8
) (
   input  logic [NUM_IRQ-1:0]        pend_vec,
   input  logic [NUM_IRQ-1:0]        act_vec,
   input  logic [NUM_IRQ-1:0]        enable,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
   output logic                      sel_valid,
   output logic [ID_W-1:0]           sel_id,
   output logic [PRIO_W-1:0]         sel_prio,
   output logic [PRIO_W-1:0]         run_prio
);
   always_comb begin
      sel_valid = 1'b0;
      sel_id    = SPURIOUS_ID;
      sel_prio  = '1;
      run_prio  = '1;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (pend_vec[i] && enable[i] && !act_vec[i] &&
             (!sel_valid || prio_flat[i*PRIO_W +: PRIO_W] < sel_prio)) begin
            sel_valid = 1'b1;
            sel_id    = ID_W'(i);
            sel_prio  = prio_flat[i*PRIO_W +: PRIO_W];
         end
         if (act_vec[i] && prio_flat[i*PRIO_W +: PRIO_W] < run_prio)
            run_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
   end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
   import irq_pend_pkg::*;
#(
   parameter int NUM_IRQ = 32,
   parameter int PRIO_W  = 8,
   localparam int ADDR_W = $clog2(NUM_IRQ),
   localparam int IDX_W  = $clog2(NUM_IRQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_lines,
   input  logic               reg_we,
   input  logic [1:0]         reg_sel,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   input  logic               ack_rd,
   output logic [9:0]         ack_id,
   input  logic               eoi_we,
   input  logic [9:0]         eoi_id,
   input  logic               clr_we,
   input  logic [9:0]         clr_id,
   output logic               irq_out,
   output logic [PRIO_W-1:0]  run_prio
);
   if (NUM_IRQ < 2 || NUM_IRQ > 1020) begin : g_bad_count
      $error("NUM_IRQ must lie in 2..1020");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must lie in 1..8");
   end

   logic [NUM_IRQ-1:0]        edge_mode, enable, pend_vec, act_vec;
   logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
   logic                      sel_valid, ack_take;
   logic [ID_W-1:0]           sel_id;
   logic [IDX_W-1:0]          sel_idx;
   logic [PRIO_W-1:0]         sel_prio;

   irq_cfg_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_cfg (
      .clk, .rst_n, .reg_we, .reg_sel, .reg_addr, .reg_wdata,
      .edge_mode, .enable, .prio_flat
   );

   irq_select #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_sel (
      .pend_vec, .act_vec, .enable, .prio_flat,
      .sel_valid, .sel_id, .sel_prio, .run_prio
   );

   assign irq_out  = sel_valid && (sel_prio < run_prio);
   assign ack_id   = irq_out ? sel_id : SPURIOUS_ID;
   assign ack_take = ack_rd && irq_out;
   assign sel_idx  = sel_id[IDX_W-1:0];

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cell
      logic ack_hit, clr_hit, eoi_hit;
      assign ack_hit = ack_take && (sel_idx == IDX_W'(i));
      assign clr_hit = clr_we && (clr_id == ID_W'(i));
      assign eoi_hit = eoi_we && (eoi_id == ID_W'(i));

      irq_pend_cell u_cell (
         .clk, .rst_n,
         .line      (irq_lines[i]),
         .edge_mode (edge_mode[i]),
         .ack_hit, .clr_hit, .eoi_hit,
         .pend      (pend_vec[i]),
         .act       (act_vec[i])
      );
   end

   assert_ack_marks_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |=> act_vec[$past(sel_idx)]);

   assert_ack_idle_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !irq_out && !eoi_we) |=> $stable(act_vec));

   assert_sel_not_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> !act_vec[sel_idx]);

   assert_idle_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec == '0) |-> (!irq_out && ack_id == SPURIOUS_ID));
endmodule

// File: tb/irq_pend_ctrl_bench.sv
`timescale 1ns/100ps
module irq_pend_ctrl_bench;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_lines = '0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        ack_rd = 1'b0;
   logic [9:0]  ack_id;
   logic        eoi_we = 1'b0;
   logic [9:0]  eoi_id = '0;
   logic        clr_we = 1'b0;
   logic [9:0]  clr_id = '0;
   logic        irq_out;
   logic [7:0]  run_prio;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   string phase = "R12";

   // behavioural reference state
   bit m_pend[N], m_act[N], m_en[N], m_edge[N], m_lq[N];
   int m_prio[N];
   int e_best, e_ack, e_run;
   bit e_irq;

   always #2.5 clk = ~clk;

   irq_pend_ctrl u_irq_pend_ctrl (
      .clk, .rst_n, .irq_lines, .reg_we, .reg_sel, .reg_addr, .reg_wdata,
      .ack_rd, .ack_id, .eoi_we, .eoi_id, .clr_we, .clr_id, .irq_out, .run_prio
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic void model_eval();
      int bp;
      e_best = -1; bp = 256; e_run = 255;
      for (int i = 0; i < N; i++) begin
         if (m_pend[i] && m_en[i] && !m_act[i] && m_prio[i] < bp) begin
            e_best = i; bp = m_prio[i];
         end
         if (m_act[i] && m_prio[i] < e_run) e_run = m_prio[i];
      end
      e_irq = (e_best >= 0) && (bp < e_run);
      e_ack = e_irq ? e_best : 1023;
   endfunction

   function automatic void model_step();
      bit take;
      take = ack_rd && e_irq;
      for (int i = 0; i < N; i++) begin
         bit ah, ch;
         ah = take && (i == e_best);
         ch = clr_we && (int'(clr_id) == i);
         if (m_edge[i]) m_pend[i] = (irq_lines[i] && !m_lq[i]) || (m_pend[i] && !ah && !ch);
         else           m_pend[i] = irq_lines[i];
         m_act[i] = ah || (m_act[i] && !(eoi_we && int'(eoi_id) == i));
         m_lq[i]  = irq_lines[i];
      end
      if (reg_we) begin
         case (reg_sel)
            2'd0: for (int j = 0; j < 16; j++)
                     if (int'(reg_addr)*16 + j < N) m_edge[int'(reg_addr)*16 + j] = reg_wdata[2*j+1];
            2'd1: for (int j = 0; j < 32; j++)
                     if (int'(reg_addr)*32 + j < N) m_en[int'(reg_addr)*32 + j] = reg_wdata[j];
            2'd2: m_prio[reg_addr] = int'(reg_wdata[7:0]);
            default: ;
         endcase
      end
   endfunction

   // compare all outputs against the model, then advance one clock
   task automatic tick();
      #1;
      model_eval();
      chk({phase, " irq_out"}, int'(irq_out), int'(e_irq));
      chk({phase, " ack_id"}, int'(ack_id), e_ack);
      chk({phase, " run_prio"}, int'(run_prio), e_run);
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic wr(int sel, int addr, logic [31:0] data);
      reg_we = 1; reg_sel = sel[1:0]; reg_addr = addr[4:0]; reg_wdata = data;
      tick();
      reg_we = 0;
   endtask

   task automatic ack();
      ack_rd = 1; tick(); ack_rd = 0;
   endtask

   task automatic eoi(int id);
      eoi_we = 1; eoi_id = id[9:0]; tick(); eoi_we = 0;
   endtask

   task automatic clr(int id);
      clr_we = 1; clr_id = id[9:0]; tick(); clr_we = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_pend[i] = 0; m_act[i] = 0; m_en[i] = 0; m_edge[i] = 0; m_lq[i] = 0; m_prio[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R12 reset irq_out", int'(irq_out), 0);
      chk("R12 reset ack_id", int'(ack_id), 1023);
      chk("R5 reset run_prio", int'(run_prio), 255);

      phase = "R4 setup";
      wr(2, 3, 32'h40); wr(2, 5, 32'h40); wr(2, 10, 32'h20); wr(2, 20, 32'h80);
      wr(0, 0, 32'h1 << 11);   // interrupt 5 edge
      wr(0, 1, 32'h1 << 9);    // interrupt 20 edge
      wr(1, 0, 32'hFFFF_FFFF);

      phase = "R1 level";
      irq_lines[3] = 1; tick();
      #1 chk("R4 single", int'(ack_id), 3);
      ack();
      #1 chk("R5 run after ack", int'(run_prio), 'h40);
      chk("R10 active excluded", int'(irq_out), 0);
      eoi(3);
      #1 chk("R6 level stays pending", int'(ack_id), 3);
      irq_lines[3] = 0; tick();
      #1 chk("R1 line low clears", int'(irq_out), 0);
      chk("R12 spurious", int'(ack_id), 1023);

      phase = "R2 edge";
      irq_lines[5] = 1; tick(); irq_lines[5] = 0; tick(); tick();
      #1 chk("R2 edge held", int'(ack_id), 5);
      clr(5);
      #1 chk("R9 edge cleared", int'(irq_out), 0);
      irq_lines[5] = 1; tick(); irq_lines[5] = 0;
      ack(); eoi(5);
      #1 chk("R6 edge cleared by ack", int'(irq_out), 0);

      phase = "R4 tie";
      irq_lines[3] = 1; irq_lines[5] = 1; tick(); irq_lines[5] = 0; tick();
      #1 chk("R4 tie lowest id", int'(ack_id), 3);
      irq_lines[10] = 1; tick();
      #1 chk("R4 urgent wins", int'(ack_id), 10);
      ack();
      #1 chk("R5 not beating run", int'(irq_out), 0);
      phase = "R7 idle ack";
      ack_rd = 1;
      #1 chk("R7 spurious ack", int'(ack_id), 1023);
      tick(); ack_rd = 0;
      #1 chk("R7 no change", int'(run_prio), 'h20);
      phase = "R8 eoi";
      eoi(20);
      #1 chk("R8 wrong id", int'(run_prio), 'h20);
      irq_lines[10] = 0; eoi(10);
      #1 chk("R8 idle restored", int'(run_prio), 'hFF);
      ack();
      phase = "R5 preempt";
      irq_lines[10] = 1; tick();
      #1 chk("R5 preempt", int'(ack_id), 10);
      phase = "R11 disable";
      wr(1, 0, ~(32'h1 << 10));
      #1 chk("R11 disabled", int'(irq_out), 0);
      wr(1, 0, 32'hFFFF_FFFF);
      irq_lines[10] = 0; tick();
      eoi(3);
      phase = "R9 level clr";
      clr(3);
      #1 chk("R9 level ignores clear", int'(ack_id), 3);
      irq_lines[3] = 0; tick();
      #1 chk("R2 edge still pending", int'(ack_id), 5);
      ack(); eoi(5);

      phase = "R3 config";
      irq_lines[20] = 1; tick(); irq_lines[20] = 0; tick(); tick();
      #1 chk("R3 word1 edge bit", int'(ack_id), 20);
      wr(0, 1, 32'h0); tick();
      #1 chk("R3 back to level", int'(irq_out), 0);
      chk("R12 nothing pending", int'(ack_id), 1023);
      ack();
      #1 chk("R7 idle ack no state", int'(run_prio), 'hFF);

      phase = "R4 random";
      wr(0, 0, 32'hAAAA_0A0A); wr(0, 1, 32'h0A0A_AAAA);
      for (int c = 0; c < 2000; c++) begin
         int r;
         r = int'($urandom_range(0, 99));
         irq_lines[$urandom_range(0, N-1)] = $urandom_range(0, 1);
         ack_rd = (r < 25);
         eoi_we = (r >= 25 && r < 45); eoi_id = 10'($urandom_range(0, N-1));
         clr_we = (r >= 45 && r < 55); clr_id = 10'($urandom_range(0, N-1));
         reg_we = (r >= 95); reg_sel = 2'd2;
         reg_addr = 5'($urandom_range(0, N-1)); reg_wdata = 32'($urandom_range(0, 255));
         tick();
      end
      ack_rd = 0; eoi_we = 0; clr_we = 0; reg_we = 0;
      tick();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule